// File: doc/BRIEF.md
# Up/Down Counter-Timer with Hold

This block is a W-bit (default 8) counter with two operating modes chosen by a mode input. In timer mode it loads a programmed value, counts down once per clock and marks the terminal count with a one-clock output pulse. It then reloads and repeats, so it acts as a periodic pulse source. A restart input brings the timer back to zero. It can be set to react to a rising edge, a falling edge, either edge, or a high level. The first period after a restart is two clocks longer than the periods that follow, because the controller passes through two arming states before it loads the count.

In FSM mode the counter is loaded with the programmed value when the mode is entered. After that it steps by one each clock, upward or downward as the direction input selects. It wraps at both ends of the range and never reloads. A hold input freezes the value. The output is high in any clock where the count is zero. The restart input has no effect in this mode.

The control state machine has five states. RESTART holds the count at zero. ARM and PRIME are the two arming states. COUNT decrements and reloads. FSM steps or holds. The transitions are:
- restart event in timer mode: any timer state goes to RESTART.
- RESTART goes to ARM, ARM goes to PRIME, and PRIME goes to COUNT, which loads the programmed value.
- COUNT goes to COUNT: a decrement, or a reload at zero.
- FSM mode selected: any non-FSM state goes to FSM, which loads the programmed value.
- timer mode selected while in FSM: FSM goes to RESTART.
- chip reset: RESTART.

Top module: `updown_pulse_timer`

## Requirements
- R1: While the chip reset is asserted, and in the first cycle after its release, the count is 0 and the pulse is high. In timer mode the pulse is low after the first clock edge.
- R2: In timer mode, the first pulse after a restart cycle comes N+3 clocks after that restart cycle, where N is the programmed value.
- R3: After each terminal-count pulse in timer mode, the count shows the programmed value N on the next clock, using the value present at that edge. It then decrements by one per clock, so the pulse repeats every N+1 clocks.
- R4: In timer mode with N of at least 1, the pulse lasts exactly one clock, unless a restart event coincides with it.
- R5: The restart select encoding is 00 for rising edge, 01 for falling edge, 10 for both edges and 11 for high level. A selected event, sensed at a clock edge against the value sampled at the previous edge, makes the count 0 and the pulse high after that edge. An edge that is not selected is ignored. A restart event takes priority over the terminal-count reload.
- R6: With select 11, the count stays 0 and the pulse stays high while the restart input is high. The pulse comes again N+3 clocks after the last held cycle.
- R7: On the first clock edge with FSM mode selected, the count is loaded with the programmed value.
- R8: In FSM mode with hold low, the count increments when the direction input is 1 and decrements when it is 0. It wraps from 255 to 0 and from 0 to 255, and it never reloads.
- R9: In FSM mode, while the hold input is high the count keeps its value.
- R10: In FSM mode the pulse is high exactly when the count is 0.
- R11: In FSM mode the restart input has no effect on the count, at any select setting.
- R12: When timer mode is selected while in FSM mode, the count goes to 0 with the pulse high on the next clock, and the timer then runs a first period of N+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register acts on its rising edge |
| rst_ni | input | 1 | Asynchronous chip reset, active low |
| fsm_mode_i | input | 1 | 0 selects timer mode, 1 selects FSM mode |
| load_val_i | input | CNT_W | Programmed value N |
| restart_i | input | 1 | Restart input (acts in timer mode only) |
| restart_sel_i | input | 2 | Restart sense: 00 rising, 01 falling, 10 both, 11 high level |
| count_up_i | input | 1 | FSM direction: 1 counts up, 0 counts down |
| hold_i | input | 1 | FSM hold: 1 freezes the count |
| tick_o | output | 1 | Terminal-count / zero pulse |
| count_o | output | CNT_W | Current count |

## Verification
A restart event and the terminal-count reload can fall on the same clock edge. The bench provokes this by running the timer down to a count of 1. It then raises the restart input, set to rising-edge sense, in the cycle where the count reads 0. It judges the result by the count after the next edge: it must be 0, with the pulse still high, rather than the reloaded value. The following gap must be the longer first period, N+3.

// File: rtl/utc_pkg.sv
package utc_pkg;

    typedef enum logic [2:0] {
        ST_RESTART = 3'd0,
        ST_ARM     = 3'd1,
        ST_PRIME   = 3'd2,
        ST_COUNT   = 3'd3,
        ST_FSM     = 3'd4
    } utc_state_e;

    typedef enum logic [1:0] {
        RSEL_RISE  = 2'b00,
        RSEL_FALL  = 2'b01,
        RSEL_BOTH  = 2'b10,
        RSEL_LEVEL = 2'b11
    } utc_rsel_e;

endpackage

// File: rtl/utc_restart_detect.sv
module utc_restart_detect
    import utc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       event_o
);

    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= restart_i;
    end

    always_comb begin
        unique case (utc_rsel_e'(sel_i))
            RSEL_RISE:  event_o = restart_i & ~prev_q;
            RSEL_FALL:  event_o = ~restart_i & prev_q;
            RSEL_BOTH:  event_o = restart_i ^ prev_q;
            RSEL_LEVEL: event_o = restart_i;
            default:    event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/utc_step.sv
module utc_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    input  logic         hold_i,
    output logic [W-1:0] fsm_next_o,
    output logic [W-1:0] dec_o,
    output logic         zero_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] inc_w;

    // Plain modulo-2^W arithmetic gives the wrap at both ends.
    assign inc_w  = cur_i + ONE;
    assign dec_o  = cur_i - ONE;
    assign zero_o = (cur_i == '0);

    always_comb begin
        if (hold_i)    fsm_next_o = cur_i;
        else if (up_i) fsm_next_o = inc_w;
        else           fsm_next_o = dec_o;
    end

endmodule

// File: rtl/utc_ctrl.sv
module utc_ctrl
    import utc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         fsm_mode_i,
    input  logic [W-1:0] load_i,
    input  logic         restart_evt_i,
    input  logic [W-1:0] fsm_next_i,
    input  logic [W-1:0] dec_i,
    input  logic         zero_i,
    output utc_state_e   state_o,
    output logic [W-1:0] count_o,
    output logic         tick_o
);

    utc_state_e   st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;

    // Next-state and next-count decision.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (fsm_mode_i) begin
            if (st_q != ST_FSM) begin
                st_d  = ST_FSM;
                cnt_d = load_i;
            end else begin
                cnt_d = fsm_next_i;
            end
        end else if (restart_evt_i) begin
            st_d  = ST_RESTART;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_RESTART: begin
                    st_d  = ST_ARM;
                    cnt_d = '0;
                end
                ST_ARM: begin
                    st_d  = ST_PRIME;
                    cnt_d = '0;
                end
                ST_PRIME: begin
                    st_d  = ST_COUNT;
                    cnt_d = load_i;
                end
                ST_COUNT: begin
                    st_d  = ST_COUNT;
                    cnt_d = zero_i ? load_i : dec_i;
                end
                ST_FSM: begin
                    st_d  = ST_RESTART;
                    cnt_d = '0;
                end
                default: begin
                    st_d  = ST_RESTART;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_RESTART;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs: the arming states suppress the zero pulse.
    always_comb begin
        state_o = st_q;
        count_o = cnt_q;
        unique case (st_q)
            ST_ARM, ST_PRIME: tick_o = 1'b0;
            default:          tick_o = zero_i;
        endcase
    end

endmodule

// File: rtl/updown_pulse_timer.sv
module updown_pulse_timer
    import utc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fsm_mode_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             restart_i,
    input  logic [1:0]       restart_sel_i,
    input  logic             count_up_i,
    input  logic             hold_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] count_o
);

    utc_state_e       st_w;
    logic             restart_evt_w;
    logic [CNT_W-1:0] fsm_next_w;
    logic [CNT_W-1:0] dec_w;
    logic             zero_w;

    utc_restart_detect u_detect (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(restart_i),
        .sel_i    (restart_sel_i),
        .event_o  (restart_evt_w)
    );

    utc_step #(.W(CNT_W)) u_step (
        .cur_i     (count_o),
        .up_i      (count_up_i),
        .hold_i    (hold_i),
        .fsm_next_o(fsm_next_w),
        .dec_o     (dec_w),
        .zero_o    (zero_w)
    );

    utc_ctrl #(.W(CNT_W)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fsm_mode_i   (fsm_mode_i),
        .load_i       (load_val_i),
        .restart_evt_i(restart_evt_w),
        .fsm_next_i   (fsm_next_w),
        .dec_i        (dec_w),
        .zero_i       (zero_w),
        .state_o      (st_w),
        .count_o      (count_o),
        .tick_o       (tick_o)
    );

endmodule

// File: rtl/utc_checker.sv
module utc_checker
    import utc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         fsm_mode_i,
    input  logic [W-1:0] load_val_i,
    input  logic         count_up_i,
    input  logic         hold_i,
    input  logic         restart_evt_i,
    input  utc_state_e   st_i,
    input  logic         tick_o,
    input  logic [W-1:0] count_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fsm_mode_i && st_i == ST_COUNT && count_o == '0 && !restart_evt_i)
        |=> (count_o == $past(load_val_i)));

    a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fsm_mode_i && restart_evt_i) |=> (count_o == '0 && tick_o));

    a_r7_fsm_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_mode_i && st_i != ST_FSM) |=> (count_o == $past(load_val_i)));

    a_r8_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_mode_i && st_i == ST_FSM && !hold_i && count_up_i)
        |=> (count_o == W'($past(count_o) + ONE)));

    a_r8_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_mode_i && st_i == ST_FSM && !hold_i && !count_up_i)
        |=> (count_o == W'($past(count_o) - ONE)));

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_mode_i && st_i == ST_FSM && hold_i) |=> $stable(count_o));

    a_r10_fsm_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_FSM) |-> (tick_o == (count_o == '0)));

    a_r12_leave_fsm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fsm_mode_i && st_i == ST_FSM) |=> (count_o == '0 && tick_o));

endmodule

bind updown_pulse_timer utc_checker #(.W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fsm_mode_i   (fsm_mode_i),
    .load_val_i   (load_val_i),
    .count_up_i   (count_up_i),
    .hold_i       (hold_i),
    .restart_evt_i(restart_evt_w),
    .st_i         (st_w),
    .tick_o       (tick_o),
    .count_o      (count_o)
);

// File: tb/updown_pulse_timer_tb.sv
`timescale 1ns/1ps
module updown_pulse_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] nval = 8'd4;
    logic       rin = 1'b0;
    logic [1:0] rsel = 2'b00;
    logic       up = 1'b1;
    logic       hold = 1'b0;
    logic       tick;
    logic [7:0] cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    updown_pulse_timer #(.CNT_W(8)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .fsm_mode_i   (mode),
        .load_val_i   (nval),
        .restart_i    (rin),
        .restart_sel_i(rsel),
        .count_up_i   (up),
        .hold_i       (hold),
        .tick_o       (tick),
        .count_o      (cnt)
    );

    task automatic tick_clk();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            tick_clk();
            n++;
        end while (!tick && n < 600);
    endtask

    task automatic test_reset();
        int g;
        rst_n = 1'b0; mode = 1'b0; nval = 8'd4;
        repeat (3) tick_clk();
        chk("R1 tick in reset", tick, 1);
        chk("R1 count in reset", cnt, 0);
        rst_n = 1'b1;
        chk("R1 tick first cycle", tick, 1);
        tick_clk();
        chk("R1 tick after first edge", tick, 0);
        gap(g);
        chk("R2 first period N=4", g + 1, 7);
    endtask

    task automatic test_periods();
        int g;
        tick_clk();
        chk("R3 reload value", cnt, 4);
        chk("R4 pulse width", tick, 0);
        gap(g);
        chk("R3 period N=4", g + 1, 5);
        gap(g);
        chk("R3 second period N=4", g, 5);
        nval = 8'd1;
        gap(g);
        chk("R3 period N=1", g, 2);
        tick_clk();
        chk("R4 pulse width N=1", tick, 0);
        nval = 8'd5;
        gap(g);
        gap(g);
        chk("R3 period N=5", g, 6);
    endtask

    task automatic test_rise();
        int g;
        rsel = 2'b00;
        tick_clk();
        rin = 1'b1;
        tick_clk();
        chk("R5 rising restart count", cnt, 0);
        chk("R5 rising restart tick", tick, 1);
        rin = 1'b0;
        gap(g);
        chk("R2 period after rising restart", g, 8);
    endtask

    task automatic test_fall();
        int g;
        rsel = 2'b01;
        tick_clk();
        rin = 1'b1;
        tick_clk();
        chk("R5 rising ignored under falling sense", cnt, 4);
        rin = 1'b0;
        tick_clk();
        chk("R5 falling restart count", cnt, 0);
        chk("R5 falling restart tick", tick, 1);
        gap(g);
        chk("R2 period after falling restart", g, 8);
    endtask

    task automatic test_both();
        int g;
        rsel = 2'b10;
        tick_clk();
        rin = 1'b1;
        tick_clk();
        chk("R5 both-edge rise restart", cnt, 0);
        tick_clk();
        chk("R2 arming cycle tick", tick, 0);
        rin = 1'b0;
        tick_clk();
        chk("R5 both-edge fall restart", tick, 1);
        gap(g);
        chk("R2 period after both-edge restart", g, 8);
    endtask

    task automatic test_level();
        int g;
        rsel = 2'b11;
        tick_clk();
        rin = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick_clk();
            chk("R6 level held count", cnt, 0);
            chk("R6 level held tick", tick, 1);
        end
        rin = 1'b0;
        tick_clk();
        chk("R6 release tick", tick, 0);
        gap(g);
        chk("R6 period after release", g + 1, 8);
    endtask

    task automatic test_coincide();
        int g;
        rsel = 2'b00;
        nval = 8'd3;
        tick_clk();
        chk("R3 reload N=3", cnt, 3);
        tick_clk();
        tick_clk();
        tick_clk();
        chk("R3 terminal count tick", tick, 1);
        rin = 1'b1;
        tick_clk();
        chk("R5 restart beats reload count", cnt, 0);
        chk("R5 restart beats reload tick", tick, 1);
        rin = 1'b0;
        gap(g);
        chk("R2 period after coincident restart", g, 6);
    endtask

    task automatic test_fsm();
        mode = 1'b1; nval = 8'd250; up = 1'b1; hold = 1'b0;
        tick_clk();
        chk("R7 fsm load", cnt, 250);
        chk("R10 nonzero tick", tick, 0);
        for (int i = 251; i <= 255; i++) begin
            tick_clk();
            chk("R8 count up", cnt, i);
        end
        tick_clk();
        chk("R8 wrap up to 0", cnt, 0);
        chk("R10 zero tick", tick, 1);
        tick_clk();
        chk("R8 after wrap", cnt, 1);
        hold = 1'b1;
        nval = 8'd77;
        tick_clk();
        chk("R9 hold", cnt, 1);
        tick_clk();
        chk("R9 hold again", cnt, 1);
        hold = 1'b0; up = 1'b0;
        tick_clk();
        chk("R8 count down", cnt, 0);
        chk("R10 zero tick down", tick, 1);
        tick_clk();
        chk("R8 wrap down no reload", cnt, 255);
        rsel = 2'b00; rin = 1'b1;
        tick_clk();
        chk("R11 rising ignored", cnt, 254);
        rsel = 2'b11;
        tick_clk();
        chk("R11 level ignored", cnt, 253);
        rin = 1'b0;
        tick_clk();
        chk("R11 release ignored", cnt, 252);
    endtask

    task automatic test_leave();
        int g;
        rsel = 2'b00; mode = 1'b0; nval = 8'd2;
        tick_clk();
        chk("R12 leave fsm count", cnt, 0);
        chk("R12 leave fsm tick", tick, 1);
        gap(g);
        chk("R12 first period N=2", g, 5);
    endtask

    initial begin
        test_reset();
        test_periods();
        test_rise();
        test_fall();
        test_both();
        test_level();
        test_coincide();
        test_fsm();
        test_leave();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule